// File: doc/BRIEF.md
# Dual-Width Countdown Timer

The block holds two countdown timers behind one small register bus. Timer 0 is 23 bits wide and timer 1 is 32 bits wide. Each timer has a reload value, a readable counter, a control word, a pending-flag register and (timer 1 only) an alarm compare value. While running, the counter steps down once per prescaled tick. The tick is the system clock divided by 1, 16 or 256. When the counter runs out, a pending flag is raised. The counter then either stops at zero or starts again from its reload value.

Each timer drives its own interrupt line. The line is gated by an enable bit. It either follows the pending flag as a level or gives a single-cycle pulse when the flag sets. Software clears the flag by writing a one to the pending register. The bus is single-cycle: a write takes effect at the clock edge where select and write-enable are high, and read data is combinational from the address.

Top module: `dual_tick_timer`

## Requirements
- R1: Bit 5 of the byte address picks the timer. Bits 4:2 pick the register: 0 reload, 1 counter, 2 control, 3 pending, 4 alarm. An access takes effect only with select high and bits 1:0 zero. Writes also need write-enable. Other register indices, and reads with select low, return zero.
- R2: Timer 0 keeps 23 bits of reload and counter and timer 1 keeps 32 bits. Bits above the width read as zero.
- R3: A reload-register write also places the written value in the counter at the same edge.
- R4: The control word has these fields: bit 8 interrupt enable, bit 7 run, bit 6 auto-reload, bits 3:1 divider code, bit 0 pulse mode. The fields read back where they were written and all other bits read zero.
- R5: Divider code 2 gives one tick per 16 clocks and code 4 gives one tick per 256 clocks. Every other code gives one tick per clock. After a control write that sets run, the first tick lands D edges later, where D is the division.
- R6: A tick while the counter holds 1 is an expiry and raises the pending flag. Without auto-reload the counter stays at 0, and further ticks change nothing.
- R7: With auto-reload, an expiry puts the reload value into the counter instead of 0, so a reload value N repeats every N ticks.
- R8: On timer 1, a tick that moves the counter down to the alarm value raises the pending flag. Timer 0 has no alarm: its alarm index reads zero and ignores writes.
- R9: The pending flag reads in bit 0 of the pending register. It stays set until a write with bit 0 = 1 clears it. A write with bit 0 = 0 has no effect, and a set in the same cycle as a clear wins.
- R10: In level mode (bit 0 = 0) the interrupt line equals the pending flag ANDed with the interrupt enable.
- R11: In pulse mode the line is high for exactly the one cycle after the edge where the flag goes from clear to set, and only while the interrupt enable is on.
- R12: With run clear the counter holds its value whatever the divider code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 6 | Byte address: bit 5 timer, bits 4:2 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 2 | Interrupt line per timer |

## Verification
A bad divider count or counter value shows in the counter read on the very cycle it goes wrong, because the bench reads the counter every cycle of each sweep. A pending flag that sets early, late or twice appears in the pending read and the interrupt line within one cycle. For a slow divider setting, however, a wrong prescaler phase shows only at the next tick, up to 256 cycles later. A pulse-mode interrupt that lasts two cycles shows on the next sample.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    localparam int BUS_W       = 32;
    localparam int IDX_W       = 3;
    localparam int MID_SHIFT   = 4;
    localparam int SLOW_SHIFT  = 8;

    localparam logic [IDX_W-1:0] IDX_RELOAD = 3'd0;
    localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_PEND   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ALARM  = 3'd4;

    localparam logic [2:0] CODE_MID  = 3'd2;
    localparam logic [2:0] CODE_SLOW = 3'd4;

    typedef struct packed {
        logic       irq_en;
        logic       run;
        logic       auto_rl;
        logic [2:0] div_code;
        logic       pulse_mode;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(logic [BUS_W-1:0] w);
        ctrl_t c;
        c.irq_en     = w[8];
        c.run        = w[7];
        c.auto_rl    = w[6];
        c.div_code   = w[3:1];
        c.pulse_mode = w[0];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(ctrl_t c);
        logic [BUS_W-1:0] w;
        w      = '0;
        w[8]   = c.irq_en;
        w[7]   = c.run;
        w[6]   = c.auto_rl;
        w[3:1] = c.div_code;
        w[0]   = c.pulse_mode;
        return w;
    endfunction

endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler
    import dtt_pkg::*;
#(
    parameter int DIV_W = SLOW_SHIFT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    localparam logic [DIV_W-1:0] LIM_MID  = DIV_W'((1 << MID_SHIFT) - 1);
    localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'((1 << SLOW_SHIFT) - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        case (div_code)
            CODE_MID:  limit = LIM_MID;
            CODE_SLOW: limit = LIM_SLOW;
            default:   limit = '0;
        endcase
        tick = run && (cnt_q == limit);
        if (restart || !run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dtt_channel.sv
module dtt_channel
    import dtt_pkg::*;
#(
    parameter int W         = 32,
    parameter bit HAS_ALARM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq,
    output logic             pend_o,
    output logic             pulse_mode_o,
    output logic             irq_en_o
);
    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] count;
        logic [W-1:0] alarm;
        ctrl_t        ctrl;
        logic         pend;
        logic         pulse;
    } state_t;

    state_t st_d, st_q;
    logic   tick;
    logic   ctrl_wr;
    logic   expire;
    logic   alarm_hit;
    logic   set_evt;
    logic [W-1:0] dec;

    assign ctrl_wr = wr_en && (reg_idx == IDX_CTRL);

    dtt_prescaler #(.DIV_W(SLOW_SHIFT)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.ctrl.run),
        .restart  (ctrl_wr),
        .div_code (st_q.ctrl.div_code),
        .tick     (tick)
    );

    always_comb begin
        st_d      = st_q;
        dec       = st_q.count - W'(1);
        expire    = tick && (st_q.count == W'(1));
        alarm_hit = HAS_ALARM && tick && (st_q.count != '0) && (dec == st_q.alarm);
        set_evt   = expire || alarm_hit;

        if (tick && (st_q.count != '0)) begin
            if (expire) begin
                st_d.count = st_q.ctrl.auto_rl ? st_q.reload : '0;
            end else begin
                st_d.count = dec;
            end
        end

        if (wr_en) begin
            case (reg_idx)
                IDX_RELOAD: begin
                    st_d.reload = wdata[W-1:0];
                    st_d.count  = wdata[W-1:0];
                end
                IDX_CTRL: st_d.ctrl = ctrl_unpack(wdata);
                IDX_PEND: begin
                    if (wdata[0]) begin
                        st_d.pend = 1'b0;
                    end
                end
                IDX_ALARM: begin
                    if (HAS_ALARM) begin
                        st_d.alarm = wdata[W-1:0];
                    end
                end
                default: ;
            endcase
        end

        if (set_evt) begin
            st_d.pend = 1'b1;
        end
        st_d.pulse = set_evt && !st_q.pend && st_q.ctrl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_idx)
            IDX_RELOAD: rdata[W-1:0] = st_q.reload;
            IDX_COUNT:  rdata[W-1:0] = st_q.count;
            IDX_CTRL:   rdata = ctrl_pack(st_q.ctrl);
            IDX_PEND:   rdata[0] = st_q.pend;
            IDX_ALARM: begin
                if (HAS_ALARM) begin
                    rdata[W-1:0] = st_q.alarm;
                end
            end
            default: ;
        endcase
    end

    assign irq          = st_q.ctrl.irq_en && (st_q.ctrl.pulse_mode ? st_q.pulse : st_q.pend);
    assign pend_o       = st_q.pend;
    assign pulse_mode_o = st_q.ctrl.pulse_mode;
    assign irq_en_o     = st_q.ctrl.irq_en;

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int NARROW_W = 23,
    parameter int WIDE_W   = 32,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [1:0]        irq
);
    localparam int NUM_CH  = 2;
    localparam int CH_BIT  = ADDR_W - 1;

    logic              acc_ok;
    logic [IDX_W-1:0]  idx;
    logic [BUS_W-1:0]  ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] pend_w;
    logic [NUM_CH-1:0] pulse_w;
    logic [NUM_CH-1:0] ie_w;

    assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
    assign idx    = bus_addr[IDX_W+1:2];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int W = (g == 0) ? NARROW_W : WIDE_W;
        logic wr_here;
        assign wr_here = acc_ok && bus_we && (bus_addr[CH_BIT] == 1'(g));

        dtt_channel #(
            .W         (W),
            .HAS_ALARM (g == 1)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_here),
            .reg_idx      (idx),
            .wdata        (bus_wdata),
            .rdata        (ch_rdata[g]),
            .irq          (irq[g]),
            .pend_o       (pend_w[g]),
            .pulse_mode_o (pulse_w[g]),
            .irq_en_o     (ie_w[g])
        );
    end

    assign bus_rdata = acc_ok ? ch_rdata[bus_addr[CH_BIT]] : '0;

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
    parameter int NARROW_W = 23,
    parameter int ADDR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        irq,
    input logic [1:0]        pend_w,
    input logic [1:0]        pulse_w,
    input logic [1:0]        ie_w
);
    localparam int CH_BIT = ADDR_W - 1;

    logic narrow_read;
    logic narrow_alarm_read;
    assign narrow_read = bus_sel && !bus_we && (bus_addr[1:0] == 2'b00)
                         && !bus_addr[CH_BIT] && (bus_addr[4:2] <= 3'd1);
    assign narrow_alarm_read = bus_sel && (bus_addr[1:0] == 2'b00)
                               && !bus_addr[CH_BIT] && (bus_addr[4:2] == 3'd4);

    p_narrow_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_read |-> (bus_rdata[31:NARROW_W] == '0));

    p_no_narrow_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_alarm_read |-> (bus_rdata == '0));

    for (genvar g = 0; g < 2; g++) begin : g_chk
        logic clr_here;
        assign clr_here = bus_sel && bus_we && (bus_addr[1:0] == 2'b00)
                          && (bus_addr[CH_BIT] == 1'(g)) && (bus_addr[4:2] == 3'd3)
                          && bus_wdata[0];

        p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_w[g] && !clr_here) |=> pend_w[g]);

        p_irq_rise_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> pend_w[g]);

        p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ie_w[g] |-> !irq[g]);

        p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_w[g] && irq[g]) |=> (!irq[g] || !pulse_w[g]));
    end

endmodule

bind dual_tick_timer dtt_checker #(
    .NARROW_W (NARROW_W),
    .ADDR_W   (ADDR_W)
) u_dtt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend_w    (pend_w),
    .pulse_w   (pulse_w),
    .ie_w      (ie_w)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_tick_timer i_dual_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr_raw(input logic [5:0] a, input logic [31:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input int ch, input int idx, input logic [31:0] d);
        wr_raw(6'((ch << 5) | (idx << 2)), d, 1'b1);
    endtask

    task automatic rd_raw(input logic [5:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd(input int ch, input int idx, output logic [31:0] v);
        rd_raw(6'((ch << 5) | (idx << 2)), v);
    endtask

    function automatic int div_of(input int code);
        if (code == 2) return 16;
        if (code == 4) return 256;
        return 1;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit ie, input bit run, input bit au,
                                              input int code, input bit pm);
        return (32'(ie) << 8) | (32'(run) << 7) | (32'(au) << 6) | (32'(code) << 1) | 32'(pm);
    endfunction

    // Sweep: one divider code, reload mode and interrupt style on one timer
    task automatic run_case(input int ch, input int code, input bit au, input bit pm);
        int d = div_of(code);
        int n = (d == 256) ? 2 : 5;
        int steps = au ? (2 * n * d + 2) : (n * d + d + 2);
        logic [31:0] v;
        wr(ch, 2, 32'h0);
        wr(ch, 3, 32'h1);
        wr(ch, 0, 32'(n));
        wr(ch, 2, ctrl_word(1'b1, 1'b1, au, code, pm));
        for (int m = 1; m <= steps; m++) begin
            int t;
            int exp_cnt;
            bit exp_pend;
            bit exp_irq;
            @(negedge clk);
            t = m / d;
            if (au) exp_cnt = n - (t % n);
            else    exp_cnt = (t >= n) ? 0 : n - t;
            exp_pend = (t >= n);
            exp_irq  = pm ? (m == n * d) : exp_pend;
            rd(ch, 1, v);
            check(au ? "R5/R7 count" : "R5/R6 count", v, 32'(exp_cnt));
            rd(ch, 3, v);
            check("R6/R9 pending", v, 32'(exp_pend));
            check(pm ? "R11 pulse irq" : "R10 level irq", 32'(irq[ch]), 32'(exp_irq));
        end
        wr(ch, 2, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        for (int ch = 0; ch < 2; ch++) begin
            for (int idx = 0; idx < 5; idx++) begin
                rd(ch, idx, v);
                check("R1 reset value", v, 32'h0);
            end
        end
        check("R10 reset irq", 32'(irq), 32'h0);

        // R2 widths and R3 load copies into counter
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, v); check("R2 narrow reload", v, 32'h007F_FFFF);
        rd(0, 1, v); check("R3 narrow count copy", v, 32'h007F_FFFF);
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, v); check("R2 wide reload", v, 32'hFFFF_FFFF);
        rd(1, 1, v); check("R3 wide count copy", v, 32'hFFFF_FFFF);

        // R1 write with select low or misaligned is ignored; unused index reads zero
        wr_raw(6'h00, 32'h1234, 1'b0);
        rd(0, 0, v); check("R1 deselected write", v, 32'h007F_FFFF);
        wr_raw(6'h21, 32'h55, 1'b1);
        rd(1, 0, v); check("R1 misaligned write", v, 32'hFFFF_FFFF);
        rd(1, 5, v); check("R1 unused index", v, 32'h0);

        // R4 control readback
        wr(0, 2, 32'hFFFF_FFFF);
        rd(0, 2, v); check("R4 control fields", v, 32'h0000_01CF);
        wr(0, 2, 32'h0);
        rd(0, 2, v); check("R4 control cleared", v, 32'h0);

        // R12 no counting while run is clear
        wr(1, 0, 32'd7);
        wr(1, 2, ctrl_word(1'b1, 1'b0, 1'b0, 0, 1'b0));
        repeat (20) @(negedge clk);
        rd(1, 1, v); check("R12 held counter", v, 32'd7);

        // R8 alarm on wide timer; narrow timer has none
        wr(0, 4, 32'h55);
        rd(0, 4, v); check("R8 narrow alarm absent", v, 32'h0);
        wr(1, 2, 32'h0);
        wr(1, 3, 32'h1);
        wr(1, 4, 32'd6);
        rd(1, 4, v); check("R8 alarm readback", v, 32'd6);
        wr(1, 0, 32'd10);
        wr(1, 2, ctrl_word(1'b1, 1'b1, 1'b0, 0, 1'b0));
        repeat (3) @(negedge clk);
        rd(1, 3, v); check("R8 before alarm", v, 32'h0);
        @(negedge clk);
        rd(1, 3, v); check("R8 alarm pending", v, 32'h1);
        rd(1, 1, v); check("R8 count at alarm", v, 32'd6);
        wr(1, 2, ctrl_word(1'b1, 1'b0, 1'b0, 0, 1'b0));

        // R9 pending clear semantics
        wr(1, 3, 32'h0);
        rd(1, 3, v); check("R9 zero write keeps pending", v, 32'h1);
        wr(1, 3, 32'h1);
        rd(1, 3, v); check("R9 clear", v, 32'h0);

        // R10 interrupt enable gating in level mode
        wr(0, 2, 32'h0);
        wr(0, 3, 32'h1);
        wr(0, 0, 32'd2);
        wr(0, 2, ctrl_word(1'b0, 1'b1, 1'b0, 0, 1'b0));
        repeat (2) @(negedge clk);
        rd(0, 3, v); check("R10 pending without enable", v, 32'h1);
        check("R10 irq masked", 32'(irq[0]), 32'h0);
        wr(0, 2, ctrl_word(1'b1, 1'b0, 1'b0, 0, 1'b0));
        check("R10 irq unmasked", 32'(irq[0]), 32'h1);
        wr(0, 3, 32'h1);
        check("R10 irq after clear", 32'(irq[0]), 32'h0);

        // Sweeps
        wr(1, 4, 32'hFFFF_FFFF);
        for (int ch = 0; ch < 2; ch++) begin
            for (int code = 0; code < 8; code++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    run_case(ch, code, mode[0], mode[1]);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule